// File: doc/BRIEF.md
# Converter Clock Prescaler with Source Select

This block produces the clock enable that paces an analog-to-digital converter. It holds one byte-wide control register that the processor bus can write. The register has two fields: a single bit that picks a tick source, and a 3-bit divide code. The tick source is either the processor bus clock or the oscillator reference. Both sources arrive as single-cycle tick strobes in the one system clock domain, so no clock is switched inside the block.

The selected ticks are counted by a divider. Each time the divider completes a period it emits a one-cycle enable pulse. The period is a power of two from 1 to 16 ticks. Software should pick a source and code that bring the pulse rate close to 1 MHz, because a converter paced too slowly gives wrong results.

Whenever a write changes the active setup, the divider restarts from zero, so the first pulse under the new setup comes only after a full new period. Reset is asynchronous and active low. Its release is synchronised with two flops, so the logic starts running on the third rising clock edge after `rst_n` goes high.

Top module: `cnv_clk_prescaler`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `conv_ce` is low. This means divide code 000 and the oscillator as the source.
- R2: A write with `wr_en` high stores `wr_data[7:5]` as the divide code and `wr_data[4]` as the source bit. The new byte appears on `rd_data` one cycle later. Bits 3:0 always read 0, and writing them has no effect.
- R3: Source bit 1 selects `bus_tick` and source bit 0 selects `osc_tick`. Ticks on the source that is not selected never advance the divider.
- R4: Divide code 000 gives one `conv_ce` pulse for every selected tick.
- R5: Divide codes 001, 010 and 011 give one pulse on every 2nd, 4th and 8th selected tick, counted from the last restart.
- R6: Divide codes 100 to 111 all give one pulse on every 16th selected tick, whatever the two low bits hold.
- R7: `conv_ce` rises in the clock cycle right after the selected tick that completes a period, and it stays high for exactly one cycle per completed period.
- R8: A write that changes the divide code or the source bit clears the divider. A tick in that same cycle is not counted, and no pulse follows in the next cycle.
- R9: A write that leaves both the divide code and the source bit unchanged does not disturb the divider count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_tick | input | 1 | One-cycle strobe for each bus clock period |
| osc_tick | input | 1 | One-cycle strobe for each oscillator period |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write byte |
| rd_data | output | 8 | Register readback byte |
| conv_ce | output | 1 | Converter clock enable pulse |

## Verification
Two results have fixed timing. A write shows on `rd_data` one cycle later. A completing tick produces `conv_ce` one cycle later. A configuration-changing write forces `conv_ce` low in the next cycle. The bench drives inputs just after the falling edge, and a behavioural model updates on the rising edge from those same stable inputs. The design's outputs are then compared against the model at the following falling edge, so every output is checked once per cycle, exactly where the one-register delay says its value is due. Stimulus covers sparse and dense tick patterns on both sources, all eight divide codes, and rewrites in the middle of a period, both with and without a change.

// File: rtl/cnv_pre_pkg.sv
package cnv_pre_pkg;

  // Register byte geometry
  localparam int REG_W     = 8;
  localparam int PRE_W     = 3;
  localparam int PRE_LSB   = 5;
  localparam int SEL_BIT   = 4;

  // Largest power-of-two exponent; higher codes saturate here
  localparam int MAX_SHIFT = 4;
  localparam int CNT_W     = MAX_SHIFT;

  // Mask of bits that are implemented in the register byte
  localparam logic [REG_W-1:0] IMPL_MASK =
    REG_W'(((1 << PRE_W) - 1) << PRE_LSB) | REG_W'(1 << SEL_BIT);

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             use_bus;
  } cfg_t;

  // Terminal count for a divide code: 2^min(code, MAX_SHIFT) - 1
  function automatic logic [CNT_W-1:0] div_limit(input logic [PRE_W-1:0] code);
    int shift;
    int lim;
    shift = (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
    lim   = (1 << shift) - 1;
    return CNT_W'(lim);
  endfunction

endpackage

// File: rtl/cnv_rst_sync.sv
module cnv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cnv_ctrl_reg.sv
module cnv_ctrl_reg
  import cnv_pre_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output cfg_t             cfg_o,
  output logic             cfg_chg_o,
  output logic [REG_W-1:0] rd_data_o
);

  logic [REG_W-1:0] reg_q;
  logic [REG_W-1:0] reg_d;
  logic [REG_W-1:0] wr_masked;
  logic             reg_en;

  // Only implemented bits are ever stored
  always_comb begin
    wr_masked = wr_data & IMPL_MASK;
    reg_en    = wr_en;
    reg_d     = reg_q;
    if (reg_en) begin
      reg_d = wr_masked;
    end
    cfg_chg_o = wr_en && (wr_masked != reg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else if (reg_en) begin
      reg_q <= reg_d;
    end
  end

  // Field extraction for the datapath
  always_comb begin
    cfg_o.pre     = reg_q[PRE_LSB +: PRE_W];
    cfg_o.use_bus = reg_q[SEL_BIT];
  end

  // Readback: implemented bits from storage, others tied low
  for (genvar b = 0; b < REG_W; b++) begin : g_rd
    if (IMPL_MASK[b]) begin : g_impl
      assign rd_data_o[b] = reg_q[b];
    end else begin : g_tie
      assign rd_data_o[b] = 1'b0;
    end
  end

  // R2
  reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (reg_q == ($past(wr_data) & IMPL_MASK)));

  // R9
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_q));

endmodule

// File: rtl/cnv_src_sel.sv
module cnv_src_sel (
  input  logic use_bus_i,
  input  logic bus_tick_i,
  input  logic osc_tick_i,
  output logic tick_o
);

  // Source selection acts as a gate on the tick strobes, not a clock mux
  always_comb begin
    if (use_bus_i) begin
      tick_o = bus_tick_i;
    end else begin
      tick_o = osc_tick_i;
    end
  end

endmodule

// File: rtl/cnv_divider.sv
module cnv_divider
  import cnv_pre_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             ce_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             ce_q;
  logic             ce_d;
  logic             at_end;

  always_comb begin
    at_end = (cnt_q >= limit_i);
    cnt_d  = cnt_q;
    ce_d   = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (at_end) begin
        cnt_d = '0;
        ce_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ce_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ce_q  <= ce_d;
    end
  end

  assign ce_o = ce_q;

  // R8
  clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0) && !ce_o);

  // R7
  ce_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_o |-> ($past(tick_i) && !$past(clr_i)));

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |-> (cnt_q <= limit_i));

  // R3
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(cnt_q) && !ce_o);

endmodule

// File: rtl/cnv_clk_prescaler.sv
module cnv_clk_prescaler
  import cnv_pre_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_tick,
  input  logic             osc_tick,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             conv_ce
);

  logic             rst_sync_n;
  cfg_t             cfg;
  logic             cfg_chg;
  logic             src_tick;
  logic [CNT_W-1:0] limit;

  cnv_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cnv_ctrl_reg i_ctrl_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cfg_o     (cfg),
    .cfg_chg_o (cfg_chg),
    .rd_data_o (rd_data)
  );

  cnv_src_sel i_src_sel (
    .use_bus_i  (cfg.use_bus),
    .bus_tick_i (bus_tick),
    .osc_tick_i (osc_tick),
    .tick_o     (src_tick)
  );

  always_comb begin
    limit = div_limit(cfg.pre);
  end

  cnv_divider i_divider (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_i  (src_tick),
    .clr_i   (cfg_chg),
    .limit_i (limit),
    .ce_o    (conv_ce)
  );

  // R3
  ce_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    conv_ce |-> ($past(rd_data[SEL_BIT]) ? $past(bus_tick) : $past(osc_tick)));

  // R4
  div1_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_en && rd_data[PRE_LSB +: PRE_W] == '0 &&
     (rd_data[SEL_BIT] ? bus_tick : osc_tick)) |=> conv_ce);

  // R2
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |=> (rd_data == ($past(wr_data) & IMPL_MASK)));

endmodule

// File: tb/test_cnv_clk_prescaler.sv
`timescale 1ns/1ps
module test_cnv_clk_prescaler;

  logic       clk;
  logic       rst_n;
  logic       bus_tick;
  logic       osc_tick;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       conv_ce;

  int    n_checks;
  int    n_fail;
  int    cyc;
  string cur_req;
  bit    finished;

  // Behavioural reference state
  int   m_code;
  int   m_sel;
  int   m_ticks;
  bit   m_ce;
  int   m_rel;
  int   lfsr;

  cnv_clk_prescaler i_cnv_clk_prescaler (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_tick (bus_tick),
    .osc_tick (osc_tick),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .conv_ce  (conv_ce)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int period_of(input int code);
    return (code >= 4) ? 16 : (1 << code);
  endfunction

  // Reference model, driven by the same stable inputs the design sees
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_sel = 0; m_ticks = 0; m_ce = 0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel = m_rel + 1;
    end else begin
      bit tk;
      int nc;
      int ns;
      tk = (m_sel == 1) ? bus_tick : osc_tick;
      m_ce = 0;
      nc = int'(wr_data[7:5]);
      ns = int'(wr_data[4]);
      if (wr_en && (nc != m_code || ns != m_sel)) begin
        m_ticks = 0;
        m_code = nc;
        m_sel = ns;
      end else if (tk) begin
        m_ticks = m_ticks + 1;
        if (m_ticks == period_of(m_code)) begin
          m_ticks = 0;
          m_ce = 1;
        end
      end
    end
  end

  task automatic compare();
    logic [7:0] exp_rd;
    exp_rd = {3'(m_code), 1'(m_sel), 4'b0000};
    n_checks++;
    if (rd_data !== exp_rd) begin
      n_fail++;
      $display("FAIL R2 cycle %0d: rd_data actual %02h expected %02h", cyc, rd_data, exp_rd);
    end
    n_checks++;
    if (conv_ce !== m_ce) begin
      n_fail++;
      $display("FAIL %s cycle %0d: conv_ce actual %0b expected %0b", cur_req, cyc, conv_ce, m_ce);
    end
  endtask

  task automatic step(input logic b, input logic o, input logic w, input logic [7:0] d);
    @(negedge clk);
    compare();
    bus_tick = b; osc_tick = o; wr_en = w; wr_data = d;
  endtask

  function automatic int rnd();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
    return lfsr;
  endfunction

  // Random ticks on both sources with given density (percent)
  task automatic run_ticks(input int cycles, input int dens);
    for (int i = 0; i < cycles; i++) begin
      int r1;
      int r2;
      r1 = rnd() % 100;
      r2 = rnd() % 100;
      step(r1 < dens, r2 < dens, 1'b0, 8'h00);
    end
  endtask

  task automatic write_reg(input logic [7:0] d);
    step(1'b1, 1'b1, 1'b1, d);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; cyc = 0; finished = 0; lfsr = 16'hACE1;
    cur_req = "R1";
    bus_tick = 0; osc_tick = 0; wr_en = 0; wr_data = 8'h00;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    n_checks++;
    if (rd_data !== 8'h00 || conv_ce !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: rd_data/conv_ce actual %02h/%0b expected 00/0", rd_data, conv_ce);
    end
    rst_n = 1;
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, 8'h00);

    // R4: divide by 1 on oscillator
    cur_req = "R4";
    run_ticks(60, 50);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0, 8'h00);

    // R3: only bus ticks while oscillator is selected
    cur_req = "R3";
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 8'h00);
    write_reg(8'h10);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0, 8'h00);
    run_ticks(60, 40);

    // R2: low bits ignored, same config rewrite
    cur_req = "R2";
    write_reg(8'h1F);
    run_ticks(10, 50);

    // R5: codes 001..011 on both sources
    cur_req = "R5";
    for (int c = 1; c <= 3; c++) begin
      write_reg(8'((c << 5) | 16'h10));
      run_ticks(120, 60);
      write_reg(8'(c << 5));
      run_ticks(120, 30);
    end

    // R6: saturated codes
    cur_req = "R6";
    for (int c = 4; c <= 7; c++) begin
      write_reg(8'((c << 5) | ((c & 1) << 4)));
      run_ticks(200, 70);
    end

    // R7: dense ticks, pulse width
    cur_req = "R7";
    write_reg(8'h20);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b0, 8'h00);
    write_reg(8'h40);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b0, 8'h00);

    // R8: changing rewrites mid-period
    cur_req = "R8";
    for (int k = 0; k < 12; k++) begin
      run_ticks(5 + k, 80);
      write_reg(8'(((k % 5) << 5) | ((k & 1) << 4)));
      for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, 8'h00);
    end

    // R9: unchanged rewrites mid-period
    cur_req = "R9";
    write_reg(8'h60);
    for (int k = 0; k < 10; k++) begin
      run_ticks(3 + k, 70);
      step(1'b1, 1'b1, 1'b1, 8'h6F);
    end
    run_ticks(40, 70);

    step(1'b0, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule